// File: doc/BRIEF.md
# ADC Conversion Sequencer with Control and Status Register

This block holds the control and status byte for one analog-to-digital converter and runs its conversions. Software reaches it over a small register bus: an address, a write strobe with write data, and a read strobe with combinational read data. A second address holds the run bit. While the run bit is set, the block issues one-cycle start pulses to an external converter and names the channel on a select bus. It waits for a done pulse after each start before it issues the next one.

There are three modes. Single mode converts one channel once and then clears the run bit. Four-channel scan converts one group of four in ascending order and repeats. Eight-channel scan converts channels 0 to 7 in order and repeats. Both scan modes run until software clears the run bit. A sticky end flag records a completed conversion or a completed pass, and an interrupt request follows it when enabled. The flag can be cleared in two ways. Software can write 0 after a read that returned the flag as 1. A transfer engine that reads the conversion result with its disable-select input low also clears it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the status byte (address STAT_ADDR, default 0) reads 0x08, the run byte (address RUN_ADDR, default 1) reads 0x00, and irq and conv_start are 0.
- R2: The status byte is laid out as bit 7 end flag, bit 6 interrupt enable, bits 5:4 mode, bit 3 constant 1, bits 2:0 channel. Bit 3 ignores writes. The run byte holds the run bit in bit 0 and reads 0 in bits 7:1.
- R3: The mode codes are 00 single, 01 four-channel scan and 10 eight-channel scan. A write of 11 to the mode field leaves the mode unchanged.
- R4: While the run bit is 1, a status write leaves mode and channel unchanged but still updates the interrupt enable.
- R5: In single mode, setting the run bit produces exactly one start pulse with conv_ch equal to the channel field. Its done pulse sets the end flag and clears the run bit.
- R6: In four-channel scan, the channels run {ch[2],00} up to {ch[2],11} in ascending order and then repeat. The end flag rises only on the done of the fourth channel in the group.
- R7: In eight-channel scan, the channels run 0 to 7 in ascending order and then repeat. The end flag rises only on the done of channel 7.
- R8: A write of 1 to bit 7 has no effect. A write of 0 clears the flag only after a status read that returned the flag as 1. One clear uses up that read.
- R9: A pulse on xfer_rd with xfer_dsel low clears the end flag. With xfer_dsel high, xfer_rd has no effect on the flag.
- R10: irq equals the end flag AND the interrupt enable bit.
- R11: Writing 0 to the run bit stops the sequence. No further start pulse is issued, and a done that arrives later does not set the flag.
- R12: conv_start is high for one cycle at a time. No new start is issued until the previous conversion's done pulse has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| conv_ch | output | 3 | Channel for the current conversion |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_done | input | 1 | Conversion-complete pulse from the converter |
| xfer_rd | input | 1 | Transfer engine reads the result |
| xfer_dsel | input | 1 | Disable-select of that transfer; high keeps the flag |
| irq | output | 1 | Conversion-end interrupt request |

## Verification
Random runs draw a mode, a channel field, an interrupt enable and a converter latency. They compare the logged channel order with the order the mode predicts, so a wrong group base, a wrong wrap point or a skipped channel shows up. The end flag is sampled twice in each scan: just before the last done of the first pass and just after it. This separates a flag set at the end of the pass from one set on every done. Directed cases cover clearing by write with and without an earlier read, transfer clears with each disable-select value, the mode code 11, writes while running, and a stop while a conversion is in flight.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 0,
  parameter logic [ADDR_W-1:0] RUN_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic [2:0]        conv_ch,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic              xfer_rd,
  input  logic              xfer_dsel,
  output logic              irq
);
  localparam logic [1:0] MD_ONE = 2'b00, MD_SCAN4 = 2'b01, MD_SCAN8 = 2'b10, MD_BAD = 2'b11;

  logic       flag_q, ie_q, start_q, armed_q, busy_q;
  logic [1:0] mode_q;
  logic [2:0] ch_q, cur_q, first_ch;
  logic       is_last;

  wire stat_wr = bus_wr && (bus_addr == STAT_ADDR);
  wire run_wr  = bus_wr && (bus_addr == RUN_ADDR);
  wire stat_rd = bus_rd && (bus_addr == STAT_ADDR);
  wire run_rd  = bus_rd && (bus_addr == RUN_ADDR);
  wire launch  = start_q && !busy_q;
  wire done_ok = conv_done && busy_q;
  wire xclr    = xfer_rd && !xfer_dsel;
  wire wclr    = stat_wr && !bus_wdata[7] && armed_q;

  assign bus_rdata = stat_rd ? {flag_q, ie_q, mode_q, 1'b1, ch_q} :
                     run_rd  ? {7'b0, start_q} : 8'h00;
  assign irq = flag_q && ie_q;

  always_comb begin
    case (mode_q)
      MD_SCAN4: begin first_ch = {ch_q[2], 2'b00}; is_last = (cur_q[1:0] == 2'b11); end
      MD_SCAN8: begin first_ch = 3'd0;             is_last = (cur_q == 3'd7);       end
      default:  begin first_ch = ch_q;             is_last = 1'b1;                  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0; ie_q <= 1'b0; start_q <= 1'b0; armed_q <= 1'b0; busy_q <= 1'b0;
      mode_q <= MD_ONE; ch_q <= '0; cur_q <= '0; conv_ch <= '0; conv_start <= 1'b0;
    end else begin
      conv_start <= launch;
      if (launch) begin
        conv_ch <= cur_q;
        busy_q  <= 1'b1;
      end
      if (done_ok) begin
        busy_q <= 1'b0;
        cur_q  <= is_last ? first_ch : cur_q + 3'd1;
        if (mode_q == MD_ONE) start_q <= 1'b0;
      end
      if (stat_wr) begin
        ie_q <= bus_wdata[6];
        if (!start_q) begin
          ch_q <= bus_wdata[2:0];
          if (bus_wdata[5:4] != MD_BAD) mode_q <= bus_wdata[5:4];
        end
      end
      if (run_wr) begin
        start_q <= bus_wdata[0];
        if (bus_wdata[0] && !start_q) cur_q <= first_ch;
        if (!bus_wdata[0]) busy_q <= 1'b0;
      end
      if (wclr || xclr) armed_q <= 1'b0;
      else if (stat_rd && flag_q) armed_q <= 1'b1;
      if (done_ok && is_last) flag_q <= 1'b1;
      else if (wclr || xclr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_start,
  input logic              conv_done,
  input logic              flag,
  input logic              start,
  input logic [1:0]        mode,
  input logic [2:0]        ch,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              xfer_rd,
  input logic              xfer_dsel
);
  wire zero_wr = bus_wr && (bus_addr == STAT_ADDR) && !bus_wdata[7];

  assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  assert_flag_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(conv_done));
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !zero_wr && !(xfer_rd && !xfer_dsel)) |=> flag);
  assert_mode_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);
  assert_cfg_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ($stable(mode) && $stable(ch)));
  assert_no_start_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(start));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
  .flag(flag_q), .start(start_q), .mode(mode_q), .ch(ch_q),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .xfer_rd(xfer_rd), .xfer_dsel(xfer_dsel)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] STAT = 2'd0, RUN = 2'd1;

  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic bus_wr = 0, bus_rd = 0, conv_done = 0, xfer_rd = 0, xfer_dsel = 0;
  logic [2:0] conv_ch;
  logic conv_start, irq;

  int checks = 0, errors = 0, log_n = 0, done_n = 0, cnt = 0, lat = 3, wide = 0, overlap = 0;
  logic prev_cs = 0;
  logic [2:0] log_ch [0:1023];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .conv_ch(conv_ch),
    .conv_start(conv_start), .conv_done(conv_done), .xfer_rd(xfer_rd),
    .xfer_dsel(xfer_dsel), .irq(irq));

  always @(negedge clk) begin
    conv_done = 0;
    if (cnt == 1) begin conv_done = 1; done_n++; end
    if (cnt > 0) cnt--;
    if (conv_start) begin
      if (prev_cs) wide++;
      if (cnt > 0) overlap++;
      if (log_n < 1024) log_ch[log_n] = conv_ch;
      log_n++;
      cnt = lat;
    end
    prev_cs = conv_start;
  end

  function automatic logic [2:0] exp_ch(int md, logic [2:0] c, int k);
    if (md == 0) return c;
    if (md == 1) return {c[2], 2'(k % 4)};
    return 3'(k % 8);
  endfunction
  function automatic int grp(int md);
    return md == 0 ? 1 : md == 1 ? 4 : 8;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask
  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask
  task automatic xfer(logic ds);
    @(negedge clk); xfer_rd = 1; xfer_dsel = ds;
    @(negedge clk); xfer_rd = 0; xfer_dsel = 0; #1;
  endtask
  task automatic run_single;
    int d;
    d = done_n;
    wr(RUN, 8'h01);
    while (done_n < d + 1) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask
  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
    end
  end

  initial begin
    logic [7:0] r;
    int b, n;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1;
    #1 chk("R1 irq", irq, 0); chk("R1 conv_start", conv_start, 0);
    rd(STAT, r); chk("R1 status", r, 8'h08);
    rd(RUN, r);  chk("R1 run", r, 8'h00);

    wr(STAT, 8'hFF); rd(STAT, r); chk("R2 R3 all-ones write", r, 8'h4F);
    wr(STAT, 8'h15); rd(STAT, r); chk("R2 layout", r, 8'h1D);
    wr(STAT, 8'h30); rd(STAT, r); chk("R3 code 11 ignored", r, 8'h18);
    wr(RUN, 8'hFE);  rd(RUN, r);  chk("R2 run byte", r, 8'h00);

    wr(STAT, 8'h43); b = log_n;
    run_single();
    chk("R5 channel", log_ch[b], 3);
    chk("R5 one pulse", log_n, b + 1);
    rd(RUN, r); chk("R5 run self-clear", r, 0);
    chk("R10 irq set", irq, 1);
    wr(STAT, 8'h43); chk("R8 write0 without read", irq, 1);
    rd(STAT, r); chk("R8 flag readback", r, 8'hCB);
    wr(STAT, 8'hC3); chk("R8 write1 no effect", irq, 1);
    wr(STAT, 8'h43); rd(STAT, r); chk("R8 armed clear", r, 8'h4B);
    chk("R10 irq cleared", irq, 0);
    run_single();
    wr(STAT, 8'h43); chk("R8 arm used up", irq, 1);
    xfer(1); chk("R9 dsel high keeps", irq, 1);
    xfer(0); chk("R9 transfer clears", irq, 0);

    lat = 6; b = log_n;
    wr(RUN, 8'h01);
    while (log_n < b + 1) @(negedge clk);
    wr(RUN, 8'h00);
    repeat (20) @(negedge clk);
    rd(STAT, r); chk("R11 late done ignored", r, 8'h4B);
    chk("R11 no more starts", log_n, b + 1);

    lat = 2;
    wr(STAT, 8'h60); b = log_n; wr(RUN, 8'h01);
    wr(STAT, 8'h07); rd(STAT, r); chk("R4 locked fields", r & 8'h7F, 8'h28);
    while (log_n < b + 16) @(negedge clk);
    wr(RUN, 8'h00); repeat (20) @(negedge clk);
    for (int k = 0; k < 16; k++) chk("R7 directed order", log_ch[b + k], exp_ch(2, 0, k));

    for (int it = 0; it < 12; it++) begin
      int md, d, g;
      logic [2:0] c;
      logic e;
      string tag;
      md = $urandom % 3; c = 3'($urandom % 8); e = 1'($urandom % 2); lat = 2 + $urandom % 4;
      tag = md == 0 ? "R5" : md == 1 ? "R6" : "R7";
      rd(STAT, r);
      if (r[7]) wr(STAT, r & 8'h7F);
      wr(STAT, {1'b0, e, 2'(md), 1'b1, c});
      b = log_n; d = done_n; g = grp(md);
      wr(RUN, 8'h01);
      if (md == 0) begin
        while (done_n < d + 1) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R5 random channel", log_ch[b], c);
        chk("R5 random count", log_n, b + 1);
        rd(STAT, r); chk("R5 random status", r, {1'b1, e, 2'b00, 1'b1, c});
        chk("R10 random irq", irq, e);
      end else begin
        while (log_n < b + g) @(negedge clk);
        rd(STAT, r); chk({tag, " flag before last done"}, r[7], 0);
        while (done_n < d + g) @(negedge clk);
        repeat (3) @(negedge clk);
        rd(STAT, r); chk({tag, " flag after pass"}, r[7], 1);
        chk("R10 random irq", irq, e);
        while (log_n < b + 2 * g) @(negedge clk);
        wr(RUN, 8'h00);
        repeat (lat + 10) @(negedge clk);
        for (int k = 0; k < 2 * g; k++) chk({tag, " order"}, log_ch[b + k], exp_ch(md, c, k));
        n = log_n; repeat (20) @(negedge clk);
        chk("R11 stopped", log_n, n);
      end
    end
    chk("R12 pulse width", wide, 0);
    chk("R12 one outstanding", overlap, 0);
    finished = 1;
    summary();
  end
endmodule